// File: doc/BRIEF.md
# Soft-Ramped Multichannel Volume Attenuator

This block sits in front of a multichannel audio DAC and scales every 24-bit signed sample by a per-channel gain. Each channel holds an 8-bit target level and an 8-bit current level. The gain applied to a sample is the current level divided by 255. Level 255 is unity, level 1 is roughly -48 dB, and level 0 silences the channel completely. The levels are linear in amplitude.

The current level never jumps to a new target. A per-channel step timer counts frame strobes, and each time it expires the current level moves one code toward the target. The step period depends on the sampling-speed mode: 4 frames per code at normal speed, 8 at double speed and 16 at quad speed. A full swing from 255 to 0 therefore takes 1020, 2040 or 4080 frames. If the target is rewritten during a ramp, the level turns toward the new target from wherever it stands, and the timer is not restarted.

Samples enter and leave through a valid/ready interface that carries a channel index. The gain used for a sample is the current level of its channel in the cycle the sample is accepted. The result is rounded to nearest and clamped to 24 bits.

Top module: `ramp_attenuator`

## Requirements
- R1: In every cycle that reset is high, all current and target levels are set to 255 and out_valid is set low. In the cycle after reset is released, in_ready is high.
- R2: An accepted sample s on a channel whose current level is L comes out as s*L/255 rounded to the nearest integer, with magnitudes rounded symmetrically about zero, as a 24-bit two's-complement value.
- R3: At current level 0, every sample comes out as exactly 0.
- R4: At current level 255, every sample comes out unchanged, including -8388608 and 8388607.
- R5: A current level changes only in a cycle with frame_tick high, and then only by one code.
- R6: speed_mode 0 gives a step every 4 frame strobes, 1 every 8, and 2 or 3 every 16. A ramp from 255 to 0 at speed_mode 0 completes on the 1020th strobe.
- R7: While a channel's current level equals its target, its timer stays at zero. When a new target is written in a cycle without a strobe, the first step lands on the period-th following strobe.
- R8: A target written during a ramp takes over from the present current level. The strobes already counted toward the next step are kept.
- R9: A target write in the same cycle as a frame strobe already governs that strobe: the strobe counts toward the new target, and if the timer expires the step heads toward the new target.
- R10: A sample accepted at one clock edge is presented on out_valid after the following edge, with its channel index on out_ch.
- R11: While out_valid is high and out_ready is low, out_sample and out_ch hold. Once both pipeline stages are full, in_ready drops.
- R12: A current level never moves past its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_mode | input | 2 | 0 normal, 1 double, 2 or 3 quad speed |
| frame_tick | input | 1 | One-cycle strobe, once per audio frame |
| lvl_wr_en | input | 1 | Writes a target level this cycle |
| lvl_wr_ch | input | 2 | Channel of the target write |
| lvl_wr_data | input | 8 | New target level |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts an input sample |
| in_ch | input | 2 | Channel of the input sample |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_ch | output | 2 | Channel of the output sample |
| out_sample | output | 24 | Scaled, rounded, clamped sample |

## Verification
A target write and a frame strobe can land on the same channel in the same cycle, and the outcome depends on which target the step logic sees. The bench drives both events together twice. The first time the channel is idle, so the strobe must start the count. The second time the timer is at its last count and the new target reverses the ramp, so the step must go the new way. Each outcome is judged by sending a probe sample of 255000, whose scaled value is exactly the level times 1000, and comparing the level read back with the level worked out from the strobe count.

// File: rtl/vol_pkg.sv
package vol_pkg;

    // Frames per level code at normal speed; double and quad speed scale it.
    localparam int STEP_FRAMES_BASE = 4;
    localparam int STEP_FRAMES_MAX  = STEP_FRAMES_BASE * 4;
    localparam int TMR_W            = $clog2(STEP_FRAMES_MAX);

    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'd0,
        SPD_DOUBLE   = 2'd1,
        SPD_QUAD     = 2'd2,
        SPD_QUAD_ALT = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_e;

    typedef logic [TMR_W-1:0] tmr_t;

    // Last timer count before a step, per speed mode.
    function automatic tmr_t step_limit(speed_e mode);
        case (mode)
            SPD_NORMAL: return tmr_t'(STEP_FRAMES_BASE - 1);
            SPD_DOUBLE: return tmr_t'(2 * STEP_FRAMES_BASE - 1);
            default:    return tmr_t'(STEP_FRAMES_MAX - 1);
        endcase
    endfunction

endpackage

// File: rtl/vol_level_track.sv
module vol_level_track
    import vol_pkg::*;
#(
    parameter int LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_tick,
    input  tmr_t               step_lim,
    input  logic               wr_en,
    input  logic [LEVEL_W-1:0] wr_level,
    output logic [LEVEL_W-1:0] cur_level,
    output logic [LEVEL_W-1:0] tgt_level
);

    localparam logic [LEVEL_W-1:0] LVL_FULL = '1;

    logic [LEVEL_W-1:0] cur_q;
    logic [LEVEL_W-1:0] tgt_q;
    logic [LEVEL_W-1:0] eff_tgt;
    tmr_t               tmr_q;
    ramp_dir_e          dir;
    logic               expire;

    always_comb begin
        // A write in this cycle already steers this cycle's decision.
        eff_tgt = wr_en ? wr_level : tgt_q;
        if (eff_tgt > cur_q) begin
            dir = DIR_UP;
        end else if (eff_tgt < cur_q) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
        expire = frame_tick && (tmr_q >= step_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= LVL_FULL;
            tgt_q <= LVL_FULL;
            tmr_q <= '0;
        end else begin
            tgt_q <= eff_tgt;
            if (dir == DIR_HOLD) begin
                tmr_q <= '0;
            end else if (frame_tick) begin
                if (expire) begin
                    tmr_q <= '0;
                    cur_q <= (dir == DIR_UP) ? cur_q + 1'b1 : cur_q - 1'b1;
                end else begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end
        end
    end

    assign cur_level = cur_q;
    assign tgt_level = tgt_q;

endmodule

// File: rtl/vol_scale_pipe.sv
module vol_scale_pipe #(
    parameter int CH_W     = 2,
    parameter int SAMPLE_W = 24,
    parameter int LEVEL_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CH_W-1:0]     in_ch,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [LEVEL_W-1:0]  in_level,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CH_W-1:0]     out_ch,
    output logic [SAMPLE_W-1:0] out_sample
);

    localparam int PROD_W = SAMPLE_W + LEVEL_W + 1;
    localparam int MAG_W  = SAMPLE_W + LEVEL_W;
    localparam int SHIFT  = MAG_W + LEVEL_W;
    localparam int RP_W   = MAG_W + SHIFT + 1;
    localparam logic [SHIFT:0]   DIVISOR   = (SHIFT+1)'((1 << LEVEL_W) - 1);
    localparam logic [SHIFT:0]   ONE_S     = {1'b1, {SHIFT{1'b0}}};
    // ceil(2^SHIFT / divisor): exact floor division for MAG_W-bit dividends.
    localparam logic [SHIFT:0]   MAGIC     = (ONE_S + DIVISOR - 1'b1) / DIVISOR;
    localparam logic [MAG_W-1:0] ROUND_OFS = MAG_W'(((1 << LEVEL_W) - 1) / 2);

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic             neg;
        logic [MAG_W-1:0] mag;
    } stage_a_t;

    typedef struct packed {
        logic [CH_W-1:0]     ch;
        logic [SAMPLE_W-1:0] smp;
    } stage_b_t;

    stage_a_t a_q, a_d;
    stage_b_t b_q, b_d;
    logic     a_v, b_v;
    logic     a_ready, b_ready;

    logic signed [PROD_W-1:0] samp_x, lvl_x, prod;
    logic [MAG_W-1:0]         x_rnd;
    logic [MAG_W:0]           quot;
    logic signed [MAG_W+1:0]  sres;
    logic [MAG_W+2-SAMPLE_W:0] sign_bits;

    assign b_ready  = !b_v || out_ready;
    assign a_ready  = !a_v || b_ready;
    assign in_ready = a_ready;

    // Stage A: signed sample times unsigned level, kept as sign and magnitude.
    always_comb begin
        samp_x   = {{(LEVEL_W+1){in_sample[SAMPLE_W-1]}}, in_sample};
        lvl_x    = {{(SAMPLE_W+1){1'b0}}, in_level};
        prod     = samp_x * lvl_x;
        a_d.ch   = in_ch;
        a_d.neg  = prod[PROD_W-1];
        a_d.mag  = MAG_W'(prod[PROD_W-1] ? -prod : prod);
    end

    // Stage B: round to nearest, divide by full scale via reciprocal, clamp.
    always_comb begin
        x_rnd     = a_q.mag + ROUND_OFS;
        quot      = (MAG_W+1)'(({{(SHIFT+1){1'b0}}, x_rnd} *
                                {{MAG_W{1'b0}}, MAGIC}) >> SHIFT);
        sres      = a_q.neg ? -$signed({1'b0, quot}) : $signed({1'b0, quot});
        sign_bits = sres[MAG_W+1:SAMPLE_W-1];
        b_d.ch    = a_q.ch;
        if ((&sign_bits) || !(|sign_bits)) begin
            b_d.smp = sres[SAMPLE_W-1:0];
        end else if (sres[MAG_W+1]) begin
            b_d.smp = {1'b1, {(SAMPLE_W-1){1'b0}}};
        end else begin
            b_d.smp = {1'b0, {(SAMPLE_W-1){1'b1}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_v <= 1'b0;
            b_v <= 1'b0;
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (a_ready) begin
                a_v <= in_valid;
                if (in_valid) begin
                    a_q <= a_d;
                end
            end
            if (b_ready) begin
                b_v <= a_v;
                if (a_v) begin
                    b_q <= b_d;
                end
            end
        end
    end

    assign out_valid  = b_v;
    assign out_ch     = b_q.ch;
    assign out_sample = b_q.smp;

endmodule

// File: rtl/ramp_attenuator.sv
module ramp_attenuator
    import vol_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    parameter int LEVEL_W  = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          speed_mode,
    input  logic                frame_tick,
    input  logic                lvl_wr_en,
    input  logic [CH_W-1:0]     lvl_wr_ch,
    input  logic [LEVEL_W-1:0]  lvl_wr_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CH_W-1:0]     in_ch,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CH_W-1:0]     out_ch,
    output logic [SAMPLE_W-1:0] out_sample
);

    logic [NUM_CH-1:0][LEVEL_W-1:0] lvl_cur;
    logic [NUM_CH-1:0][LEVEL_W-1:0] lvl_tgt;
    tmr_t                           step_lim;
    logic [LEVEL_W-1:0]             sel_level;

    assign step_lim  = step_limit(speed_e'(speed_mode));
    assign sel_level = lvl_cur[in_ch];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = lvl_wr_en && (lvl_wr_ch == CH_W'(g));

        vol_level_track #(
            .LEVEL_W (LEVEL_W)
        ) u_trk (
            .clk        (clk),
            .rst        (rst),
            .frame_tick (frame_tick),
            .step_lim   (step_lim),
            .wr_en      (hit),
            .wr_level   (lvl_wr_data),
            .cur_level  (lvl_cur[g]),
            .tgt_level  (lvl_tgt[g])
        );
    end

    vol_scale_pipe #(
        .CH_W     (CH_W),
        .SAMPLE_W (SAMPLE_W),
        .LEVEL_W  (LEVEL_W)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_ch      (in_ch),
        .in_sample  (in_sample),
        .in_level   (sel_level),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_ch     (out_ch),
        .out_sample (out_sample)
    );

endmodule

// File: rtl/ramp_attenuator_chk.sv
module ramp_attenuator_chk #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    parameter int LEVEL_W  = 8,
    parameter int CH_W     = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           frame_tick,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic [CH_W-1:0]                out_ch,
    input logic [SAMPLE_W-1:0]            out_sample,
    input logic [NUM_CH-1:0][LEVEL_W-1:0] lvl_cur,
    input logic [NUM_CH-1:0][LEVEL_W-1:0] lvl_tgt
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (lvl_cur == {NUM_CH{{LEVEL_W{1'b1}}}})));

    // R11
    hold_output_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_sample) && $stable(out_ch)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
        // R5
        single_step_chk: assert property (@(posedge clk) disable iff (rst)
            (lvl_cur[g] != $past(lvl_cur[g])) |->
                ($past(frame_tick) &&
                 ((lvl_cur[g] == $past(lvl_cur[g]) + 1'b1) ||
                  (lvl_cur[g] == $past(lvl_cur[g]) - 1'b1))));

        // R12
        no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
            (lvl_cur[g] != $past(lvl_cur[g])) |->
                ((lvl_cur[g] > $past(lvl_cur[g])) ? (lvl_cur[g] <= lvl_tgt[g])
                                                  : (lvl_cur[g] >= lvl_tgt[g])));
    end

endmodule

bind ramp_attenuator ramp_attenuator_chk #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .LEVEL_W  (LEVEL_W),
    .CH_W     (CH_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_ch     (out_ch),
    .out_sample (out_sample),
    .lvl_cur    (lvl_cur),
    .lvl_tgt    (lvl_tgt)
);

// File: tb/tb_ramp_attenuator.sv
`timescale 1ns/1ps
module tb_ramp_attenuator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  speed_mode = 2'd0;
    logic        frame_tick = 1'b0;
    logic        lvl_wr_en = 1'b0;
    logic [1:0]  lvl_wr_ch = '0;
    logic [7:0]  lvl_wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_ch = '0;
    logic [23:0] in_sample = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_ch;
    logic [23:0] out_sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ramp_attenuator dut (
        .clk(clk), .rst(rst), .speed_mode(speed_mode), .frame_tick(frame_tick),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_ch(lvl_wr_ch), .lvl_wr_data(lvl_wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_ch(in_ch), .in_sample(in_sample),
        .out_valid(out_valid), .out_ready(out_ready), .out_ch(out_ch),
        .out_sample(out_sample)
    );

    task automatic chk_eq(input string req, input string what,
                          input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_scale(input longint s, input longint lvl);
        longint p, m, q;
        p = s * lvl;
        m = (p < 0) ? -p : p;
        q = (m + 127) / 255;
        return (p < 0) ? -q : q;
    endfunction

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk) frame_tick = 1'b1;
            @(negedge clk) frame_tick = 1'b0;
        end
    endtask

    task automatic write_tgt(input int ch, input int lvl, input bit with_tick);
        @(negedge clk);
        lvl_wr_en = 1'b1; lvl_wr_ch = 2'(ch); lvl_wr_data = 8'(lvl);
        frame_tick = with_tick;
        @(negedge clk);
        lvl_wr_en = 1'b0; frame_tick = 1'b0;
    endtask

    // Send one sample with out_ready high; return the result (R10 latency).
    task automatic send(input int ch, input longint smp, output longint res);
        @(negedge clk);
        in_valid = 1'b1; in_ch = 2'(ch); in_sample = smp[23:0];
        @(negedge clk);
        in_valid = 1'b0;
        chk_eq("R10", "out_valid one cycle after accept", longint'(out_valid), 0);
        @(negedge clk);
        chk_eq("R10", "out_valid two cycles after accept", longint'(out_valid), 1);
        chk_eq("R10", "out_ch", longint'(out_ch), longint'(ch));
        res = longint'($signed(out_sample));
    endtask

    task automatic chk_level(input string req, input int ch, input int exp_lvl);
        longint r;
        send(ch, 255000, r);
        chk_eq(req, $sformatf("level of channel %0d", ch), r / 1000, exp_lvl);
    endtask

    task automatic chk_scale(input string req, input int ch, input longint s,
                             input longint lvl);
        longint r;
        send(ch, s, r);
        chk_eq(req, $sformatf("scaled %0d at level %0d", s, lvl), r, exp_scale(s, lvl));
    endtask

    task automatic test_reset();
        chk_eq("R1", "out_valid after reset", longint'(out_valid), 0);
        chk_eq("R1", "in_ready after reset", longint'(in_ready), 1);
        for (int c = 0; c < 4; c++) chk_level("R1", c, 255);
    endtask

    task automatic test_unity();
        chk_scale("R4", 0, 8388607, 255);
        chk_scale("R4", 1, -8388608, 255);
        chk_scale("R4", 2, -1, 255);
        chk_scale("R4", 3, 123456, 255);
    endtask

    task automatic test_step_timing();
        speed_mode = 2'd0;
        write_tgt(0, 250, 1'b0);
        tick(3);
        chk_level("R7", 0, 255);
        tick(1);
        chk_level("R7", 0, 254);
        tick(4);
        chk_level("R6", 0, 253);
    endtask

    task automatic test_retarget();
        tick(2);
        write_tgt(0, 255, 1'b0);
        tick(1);
        chk_level("R8", 0, 253);
        tick(1);
        chk_level("R8", 0, 254);
        tick(4);
        chk_level("R8", 0, 255);
        tick(8);
        chk_level("R12", 0, 255);
    endtask

    task automatic test_speed_modes();
        speed_mode = 2'd1;
        write_tgt(0, 253, 1'b0);
        tick(7);
        chk_level("R6", 0, 255);
        tick(1);
        chk_level("R6", 0, 254);
        speed_mode = 2'd2;
        tick(15);
        chk_level("R6", 0, 254);
        tick(1);
        chk_level("R6", 0, 253);
        speed_mode = 2'd3;
        write_tgt(0, 255, 1'b0);
        tick(15);
        chk_level("R6", 0, 253);
        tick(1);
        chk_level("R6", 0, 254);
        speed_mode = 2'd0;
        tick(4);
        chk_level("R6", 0, 255);
    endtask

    task automatic test_collision();
        // Write with strobe from idle: the strobe already counts.
        write_tgt(0, 250, 1'b1);
        tick(2);
        chk_level("R9", 0, 255);
        tick(1);
        chk_level("R9", 0, 254);
        // Write with strobe at expiry: the step follows the new target.
        tick(3);
        chk_level("R9", 0, 254);
        write_tgt(0, 255, 1'b1);
        chk_level("R9", 0, 255);
    endtask

    task automatic test_ramp_and_scale();
        speed_mode = 2'd0;
        write_tgt(1, 0, 1'b0);
        write_tgt(2, 128, 1'b0);
        write_tgt(3, 1, 1'b0);
        tick(400);
        chk_level("R6", 1, 155);
        chk_level("R6", 2, 155);
        tick(619);
        chk_level("R6", 1, 1);
        chk_level("R12", 2, 128);
        chk_level("R12", 3, 1);
        tick(1);
        chk_level("R6", 1, 0);
        chk_level("R12", 0, 255);
        chk_scale("R2", 2, 8388607, 128);
        chk_scale("R2", 2, -8388608, 128);
        chk_scale("R2", 2, 2, 128);
        chk_scale("R2", 2, 3, 128);
        chk_scale("R2", 2, -3, 128);
        chk_scale("R2", 2, 12345, 128);
        chk_scale("R2", 3, 8388607, 1);
        chk_scale("R2", 3, -200, 1);
        chk_scale("R3", 1, 8388607, 0);
        chk_scale("R3", 1, -8388608, 0);
    endtask

    task automatic test_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_ch = 2'd0; in_sample = 24'd777;
        @(negedge clk);
        in_ch = 2'd2; in_sample = 24'd888;
        @(negedge clk);
        in_ch = 2'd3; in_sample = 24'd5;
        @(negedge clk);
        chk_eq("R11", "in_ready with both stages full", longint'(in_ready), 0);
        for (int k = 0; k < 3; k++) begin
            chk_eq("R11", "held out_valid", longint'(out_valid), 1);
            chk_eq("R11", "held out_sample", longint'($signed(out_sample)), 777);
            chk_eq("R11", "held out_ch", longint'(out_ch), 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk_eq("R11", "second sample after release", longint'($signed(out_sample)),
               exp_scale(888, 128));
        chk_eq("R11", "second sample channel", longint'(out_ch), 2);
        @(negedge clk);
        chk_eq("R11", "pipeline drained", longint'(out_valid), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_unity();
        test_step_timing();
        test_retarget();
        test_speed_modes();
        test_collision();
        test_ramp_and_scale();
        test_backpressure();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule